// File: doc/BRIEF.md
# Operand Forwarding and Hazard Unit

This block resolves data and control hazards for an in-order five-stage 32-bit RISC pipeline (fetch, decode, execute, memory, write-back). It is purely combinational and sits beside the execute stage. It takes the source register indices and register-file values of the instruction in decode and of the instruction in execute, plus the destination index, write enable and result of the memory and write-back stages. It returns operand values with every pending result already folded in, together with a stall request, a flush request and a bubble indication for the pipeline registers.

Three source operands are handled side by side. A store needs an address base, an address offset and the data to write, and all three can depend on results that are still in flight. Two bypass points exist. At decode, a register read that meets a same-cycle write-back returns the value being written. At execute, the younger in-flight results replace the latched operand. A load followed at once by a consumer cannot be bypassed, so the unit asks for a single stall. A taken branch in execute flushes the two younger slots instead of predicting.

Top module: `fwd_hazard_unit`

## Requirements
- R1: A decode-stage operand whose index equals the write-back destination, with the write-back write enable high and the index non-zero, takes the write-back result. Otherwise it takes the register-file value.
- R2: Register index 0 yields zero on every decode and execute operand. This holds even when the register-file value is non-zero or a later stage names index 0 as a destination with its write enable high.
- R3: An execute operand whose non-zero index equals the memory-stage destination, with the memory-stage write enable high, takes the memory-stage result. This holds even when the write-back stage also matches.
- R4: An execute operand that does not match the memory stage, but whose non-zero index equals the write-back destination with the write-back write enable high, takes the write-back result.
- R5: An execute operand that matches neither later stage passes its latched value through unchanged.
- R6: Operand A (slot 0), operand B (slot 1) and store data D (slot 2) are each selected on their own, so one cycle can draw them from three different sources.
- R7: Stall is high exactly when there is no taken branch and the execute instruction is a load with its write enable high and a non-zero destination, and some decode operand flagged as used names that destination.
- R8: Flush is high exactly when the execute-stage branch is taken. In that cycle stall stays low, so flush wins over stall.
- R9: The bubble output, which tells the pipeline to load a no-operation with its write enable cleared into the execute slot, is high exactly when stall or flush is high.
- R10: In a five-stage pipeline driven by these outputs, every used operand seen in execute equals the value that in-order execution gives. This covers back-to-back ALU chains, load-use pairs, stores and a taken branch. There is one stall cycle per load-use pair and one flush per taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| id_src_idx | input | NSRC*REG_AW | Decode source indices, slot 0 = A, 1 = B, 2 = D |
| id_rf_val | input | NSRC*DATA_W | Register-file values read in decode |
| id_src_use | input | NSRC | Decode slot is read by the instruction |
| ex_src_idx | input | NSRC*REG_AW | Execute source indices |
| ex_src_val | input | NSRC*DATA_W | Operand values latched from decode |
| ex_dst_idx | input | REG_AW | Execute destination index |
| ex_dst_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_branch_taken | input | 1 | Execute instruction is a taken branch |
| mem_dst_idx | input | REG_AW | Memory-stage destination index |
| mem_dst_we | input | 1 | Memory-stage write enable |
| mem_result | input | DATA_W | Memory-stage result |
| wb_dst_idx | input | REG_AW | Write-back destination index |
| wb_dst_we | input | 1 | Write-back write enable |
| wb_result | input | DATA_W | Write-back result |
| id_opnd | output | NSRC*DATA_W | Decode operands after the write-back bypass |
| ex_opnd | output | NSRC*DATA_W | Execute operands after forwarding |
| stall_o | output | 1 | Hold fetch and decode for one cycle |
| flush_o | output | 1 | Discard the fetch and decode slots |
| ex_bubble_o | output | 1 | Load a no-operation into the execute slot |

## Verification
Every output is a function of the present inputs with no register on the path, so each result is due in the same cycle as its stimulus. The sweeps change inputs, wait a few nanoseconds and compare before anything else moves. In the pipeline model, the execute operands are compared at the falling edge. This is half a cycle after the rising edge that loaded the instruction into execute and before the next edge can advance it. Stall and flush are counted at those same falling edges, and each count covers one whole cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SRC_LATCH = 2'd0,
      SRC_WB    = 2'd1,
      SRC_MEM   = 2'd2,
      SRC_ZERO  = 2'd3
   } fwd_src_e;
endpackage

// File: rtl/fwd_id_bypass.sv
module fwd_id_bypass #(
   parameter int DATA_W      = 32,
   parameter int REG_AW      = 5,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  logic [REG_AW-1:0] src_idx,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [REG_AW-1:0] wb_idx,
   input  logic              wb_we,
   input  logic [DATA_W-1:0] wb_data,
   output logic [DATA_W-1:0] opnd
);
   logic is_zero_reg;
   logic wb_hit;

   generate
      if (ZERO_REG_EN) begin : g_zero
         assign is_zero_reg = (src_idx == '0);
      end else begin : g_nozero
         assign is_zero_reg = 1'b0;
      end
   endgenerate

   assign wb_hit = wb_we && (wb_idx == src_idx);

   always_comb begin
      if (is_zero_reg)  opnd = '0;
      else if (wb_hit)  opnd = wb_data;
      else              opnd = rf_val;
   end
endmodule

// File: rtl/fwd_ex_mux.sv
module fwd_ex_mux
   import fwd_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int REG_AW      = 5,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  logic [REG_AW-1:0] src_idx,
   input  logic [DATA_W-1:0] src_val,
   input  logic [REG_AW-1:0] mem_idx,
   input  logic              mem_we,
   input  logic [DATA_W-1:0] mem_data,
   input  logic [REG_AW-1:0] wb_idx,
   input  logic              wb_we,
   input  logic [DATA_W-1:0] wb_data,
   output logic [DATA_W-1:0] opnd
);
   fwd_src_e sel;
   logic     is_zero_reg;

   generate
      if (ZERO_REG_EN) begin : g_zero
         assign is_zero_reg = (src_idx == '0);
      end else begin : g_nozero
         assign is_zero_reg = 1'b0;
      end
   endgenerate

   // youngest producer first
   always_comb begin
      if (is_zero_reg)                              sel = SRC_ZERO;
      else if (mem_we && (mem_idx == src_idx))      sel = SRC_MEM;
      else if (wb_we && (wb_idx == src_idx))        sel = SRC_WB;
      else                                          sel = SRC_LATCH;
   end

   always_comb begin
      unique case (sel)
         SRC_ZERO: opnd = '0;
         SRC_MEM:  opnd = mem_data;
         SRC_WB:   opnd = wb_data;
         default:  opnd = src_val;
      endcase
   end
endmodule

// File: rtl/fwd_hazard_detect.sv
module fwd_hazard_detect #(
   parameter int REG_AW      = 5,
   parameter int NSRC        = 3,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  logic [NSRC*REG_AW-1:0] id_src_idx,
   input  logic [NSRC-1:0]        id_src_use,
   input  logic [REG_AW-1:0]      ex_dst_idx,
   input  logic                   ex_dst_we,
   input  logic                   ex_is_load,
   input  logic                   ex_branch_taken,
   output logic                   stall,
   output logic                   flush,
   output logic                   bubble
);
   logic [NSRC-1:0] hit;
   logic            dst_live;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_hit
         assign hit[i] = id_src_use[i] && (id_src_idx[i*REG_AW +: REG_AW] == ex_dst_idx);
      end
      if (ZERO_REG_EN) begin : g_zero
         assign dst_live = ex_dst_we && (ex_dst_idx != '0);
      end else begin : g_nozero
         assign dst_live = ex_dst_we;
      end
   endgenerate

   assign flush  = ex_branch_taken;
   assign stall  = !ex_branch_taken && ex_is_load && dst_live && (|hit);
   assign bubble = stall || flush;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
   parameter int DATA_W      = 32,
   parameter int REG_AW      = 5,
   parameter int NSRC        = 3,
   parameter bit ZERO_REG_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC*REG_AW-1:0] id_src_idx,
   input  logic [NSRC*DATA_W-1:0] id_rf_val,
   input  logic [NSRC-1:0]        id_src_use,
   input  logic [NSRC*REG_AW-1:0] ex_src_idx,
   input  logic [NSRC*DATA_W-1:0] ex_src_val,
   input  logic [REG_AW-1:0]      ex_dst_idx,
   input  logic                   ex_dst_we,
   input  logic                   ex_is_load,
   input  logic                   ex_branch_taken,
   input  logic [REG_AW-1:0]      mem_dst_idx,
   input  logic                   mem_dst_we,
   input  logic [DATA_W-1:0]      mem_result,
   input  logic [REG_AW-1:0]      wb_dst_idx,
   input  logic                   wb_dst_we,
   input  logic [DATA_W-1:0]      wb_result,
   output logic [NSRC*DATA_W-1:0] id_opnd,
   output logic [NSRC*DATA_W-1:0] ex_opnd,
   output logic                   stall_o,
   output logic                   flush_o,
   output logic                   ex_bubble_o
);
   localparam int NREG = 1 << REG_AW;

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
      if (REG_AW < 1 || NREG < 2) begin : g_bad_aw
         $error("REG_AW must be positive");
      end
      if (NSRC < 1) begin : g_bad_ns
         $error("NSRC must be positive");
      end
   endgenerate

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_opnd
         logic [REG_AW-1:0] ex_idx_i;
         logic [REG_AW-1:0] id_idx_i;
         assign ex_idx_i = ex_src_idx[i*REG_AW +: REG_AW];
         assign id_idx_i = id_src_idx[i*REG_AW +: REG_AW];

         fwd_id_bypass #(.DATA_W(DATA_W), .REG_AW(REG_AW), .ZERO_REG_EN(ZERO_REG_EN)) u_id (
            .src_idx (id_idx_i),
            .rf_val  (id_rf_val[i*DATA_W +: DATA_W]),
            .wb_idx  (wb_dst_idx),
            .wb_we   (wb_dst_we),
            .wb_data (wb_result),
            .opnd    (id_opnd[i*DATA_W +: DATA_W])
         );

         fwd_ex_mux #(.DATA_W(DATA_W), .REG_AW(REG_AW), .ZERO_REG_EN(ZERO_REG_EN)) u_ex (
            .src_idx  (ex_idx_i),
            .src_val  (ex_src_val[i*DATA_W +: DATA_W]),
            .mem_idx  (mem_dst_idx),
            .mem_we   (mem_dst_we),
            .mem_data (mem_result),
            .wb_idx   (wb_dst_idx),
            .wb_we    (wb_dst_we),
            .wb_data  (wb_result),
            .opnd     (ex_opnd[i*DATA_W +: DATA_W])
         );

         // R3
         mem_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_dst_we && ex_idx_i == mem_dst_idx && ex_idx_i != '0)
            |-> ex_opnd[i*DATA_W +: DATA_W] == mem_result);

         // R1
         id_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_dst_we && id_idx_i == wb_dst_idx && id_idx_i != '0)
            |-> id_opnd[i*DATA_W +: DATA_W] == wb_result);

         if (ZERO_REG_EN) begin : g_zchk
            // R2
            zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (ex_idx_i == '0) |-> ex_opnd[i*DATA_W +: DATA_W] == '0);
         end
      end
   endgenerate

   fwd_hazard_detect #(.REG_AW(REG_AW), .NSRC(NSRC), .ZERO_REG_EN(ZERO_REG_EN)) u_haz (
      .id_src_idx      (id_src_idx),
      .id_src_use      (id_src_use),
      .ex_dst_idx      (ex_dst_idx),
      .ex_dst_we       (ex_dst_we),
      .ex_is_load      (ex_is_load),
      .ex_branch_taken (ex_branch_taken),
      .stall           (stall_o),
      .flush           (flush_o),
      .bubble          (ex_bubble_o)
   );

   // R8
   flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !stall_o);

   // R7
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> (ex_is_load && ex_dst_we && |id_src_use));

   // R9
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o || flush_o) |-> ex_bubble_o);
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
   localparam int DW = 32;
   localparam int AW = 5;
   localparam int NS = 3;
   localparam int NPROG = 16;
   localparam logic [31:0] LDK = 32'h5A5A_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // sweep-driven inputs
   logic [NS*AW-1:0] s_id_idx, s_ex_idx;
   logic [NS*DW-1:0] s_id_rf, s_ex_val;
   logic [NS-1:0]    s_use;
   logic [AW-1:0]    s_ex_dst, s_mem_dst, s_wb_dst;
   logic             s_ex_we, s_ld, s_br, s_mem_we, s_wb_we;
   logic [DW-1:0]    s_mem_res, s_wb_res;

   // pipeline-shell inputs
   logic [NS*AW-1:0] p_id_idx, p_ex_idx;
   logic [NS*DW-1:0] p_id_rf, p_ex_val;
   logic [NS-1:0]    p_use;
   logic [AW-1:0]    p_ex_dst, p_mem_dst, p_wb_dst;
   logic             p_ex_we, p_ld, p_br, p_mem_we, p_wb_we;
   logic [DW-1:0]    p_mem_res, p_wb_res;

   logic shell_on = 1'b0;

   logic [NS*AW-1:0] id_idx, ex_idx;
   logic [NS*DW-1:0] id_rf, ex_val, id_opnd, ex_opnd;
   logic [NS-1:0]    use_v;
   logic [AW-1:0]    ex_dst, mem_dst, wb_dst;
   logic             ex_we, ld, br, mem_we, wb_we;
   logic [DW-1:0]    mem_res, wb_res;
   logic             stall, flush, bubble;

   assign id_idx  = shell_on ? p_id_idx  : s_id_idx;
   assign id_rf   = shell_on ? p_id_rf   : s_id_rf;
   assign use_v   = shell_on ? p_use     : s_use;
   assign ex_idx  = shell_on ? p_ex_idx  : s_ex_idx;
   assign ex_val  = shell_on ? p_ex_val  : s_ex_val;
   assign ex_dst  = shell_on ? p_ex_dst  : s_ex_dst;
   assign ex_we   = shell_on ? p_ex_we   : s_ex_we;
   assign ld      = shell_on ? p_ld      : s_ld;
   assign br      = shell_on ? p_br      : s_br;
   assign mem_dst = shell_on ? p_mem_dst : s_mem_dst;
   assign mem_we  = shell_on ? p_mem_we  : s_mem_we;
   assign mem_res = shell_on ? p_mem_res : s_mem_res;
   assign wb_dst  = shell_on ? p_wb_dst  : s_wb_dst;
   assign wb_we   = shell_on ? p_wb_we   : s_wb_we;
   assign wb_res  = shell_on ? p_wb_res  : s_wb_res;

   fwd_hazard_unit #(.DATA_W(DW), .REG_AW(AW), .NSRC(NS), .ZERO_REG_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .id_src_idx(id_idx), .id_rf_val(id_rf), .id_src_use(use_v),
      .ex_src_idx(ex_idx), .ex_src_val(ex_val),
      .ex_dst_idx(ex_dst), .ex_dst_we(ex_we), .ex_is_load(ld), .ex_branch_taken(br),
      .mem_dst_idx(mem_dst), .mem_dst_we(mem_we), .mem_result(mem_res),
      .wb_dst_idx(wb_dst), .wb_dst_we(wb_we), .wb_result(wb_res),
      .id_opnd(id_opnd), .ex_opnd(ex_opnd),
      .stall_o(stall), .flush_o(flush), .ex_bubble_o(bubble)
   );

   // ---------------- program for the pipeline shell ----------------
   typedef struct packed {
      logic [4:0] dst, sa, sb, sd;
      logic we, ldf, st, brf;
      logic [4:0] tgt;
   } ins_t;

   function automatic ins_t mk(int d, int a, int b, int s, bit w, bit l, bit t, bit j, int g);
      ins_t r;
      r.dst = 5'(d); r.sa = 5'(a); r.sb = 5'(b); r.sd = 5'(s);
      r.we = w; r.ldf = l; r.st = t; r.brf = j; r.tgt = 5'(g);
      return r;
   endfunction

   function automatic ins_t prog(logic [4:0] k);
      case (k)
         5'd0:  return mk(1, 2, 3, 0, 1, 0, 0, 0, 0);
         5'd1:  return mk(4, 1, 1, 0, 1, 0, 0, 0, 0);
         5'd2:  return mk(5, 1, 4, 0, 1, 0, 0, 0, 0);
         5'd3:  return mk(6, 1, 0, 0, 1, 0, 0, 0, 0);
         5'd4:  return mk(7, 5, 6, 0, 1, 1, 0, 0, 0);
         5'd5:  return mk(8, 7, 4, 0, 1, 0, 0, 0, 0);
         5'd6:  return mk(0, 8, 7, 5, 0, 0, 1, 0, 0);
         5'd7:  return mk(0, 8, 8, 0, 1, 0, 0, 0, 0);
         5'd8:  return mk(9, 0, 8, 0, 1, 0, 0, 0, 0);
         5'd9:  return mk(0, 9, 9, 0, 0, 0, 0, 1, 12);
         5'd10: return mk(10, 9, 9, 0, 1, 0, 0, 0, 0);
         5'd11: return mk(11, 10, 9, 0, 1, 0, 0, 0, 0);
         5'd12: return mk(12, 9, 1, 0, 1, 1, 0, 0, 0);
         5'd13: return mk(0, 2, 3, 12, 0, 0, 1, 0, 0);
         5'd14: return mk(13, 12, 13, 0, 1, 0, 0, 0, 0);
         default: return mk(14, 13, 13, 0, 1, 0, 0, 0, 0);
      endcase
   endfunction

   function automatic logic [31:0] rf_init(int i);
      return (i == 0) ? 32'd0 : (32'(i) * 32'h0000_1111 + 32'd7);
   endfunction

   // pipeline state
   logic [4:0]  pc;
   logic        fd_v, dx_v, xm_v, xm_we, xm_ld, mw_v, mw_we;
   logic [4:0]  fd_i, dx_i, xm_dst, mw_dst;
   logic [NS*DW-1:0] dx_val;
   logic [31:0] xm_res, mw_res;
   logic [31:0] rf [32];
   ins_t di, xi;

   assign di = prog(fd_i);
   assign xi = prog(dx_i);

   always_comb begin
      p_id_idx  = {di.sd, di.sb, di.sa};
      p_id_rf   = {rf[di.sd], rf[di.sb], rf[di.sa]};
      p_use     = fd_v ? {di.st, 2'b11} : 3'b000;
      p_ex_idx  = {xi.sd, xi.sb, xi.sa};
      p_ex_val  = dx_val;
      p_ex_dst  = xi.dst;
      p_ex_we   = dx_v && xi.we;
      p_ld      = dx_v && xi.ldf;
      p_br      = dx_v && xi.brf;
      p_mem_dst = xm_dst;
      p_mem_we  = xm_v && xm_we;
      p_mem_res = xm_res;
      p_wb_dst  = mw_dst;
      p_wb_we   = mw_v && mw_we;
      p_wb_res  = mw_res;
   end

   always @(posedge clk) begin
      if (!shell_on) begin
         pc <= '0; fd_v <= 1'b0; dx_v <= 1'b0; xm_v <= 1'b0; mw_v <= 1'b0;
         fd_i <= '0; dx_i <= '0; dx_val <= '0;
         xm_we <= 1'b0; xm_ld <= 1'b0; xm_dst <= '0; xm_res <= '0;
         mw_we <= 1'b0; mw_dst <= '0; mw_res <= '0;
         for (int i = 0; i < 32; i++) rf[i] <= rf_init(i);
      end else begin
         mw_v <= xm_v; mw_we <= xm_we; mw_dst <= xm_dst;
         mw_res <= xm_ld ? (xm_res ^ LDK) : xm_res;
         if (mw_v && mw_we && mw_dst != 5'd0) rf[mw_dst] <= mw_res;
         xm_v <= dx_v; xm_we <= xi.we; xm_ld <= xi.ldf; xm_dst <= xi.dst;
         xm_res <= ex_opnd[31:0] + ex_opnd[63:32];
         if (flush) begin
            fd_v <= 1'b0; dx_v <= 1'b0; pc <= xi.tgt;
         end else if (stall) begin
            dx_v <= 1'b0;
         end else begin
            dx_v <= fd_v; dx_i <= fd_i; dx_val <= id_opnd;
            if (pc < 5'(NPROG)) begin
               fd_v <= 1'b1; fd_i <= pc; pc <= pc + 5'd1;
            end else begin
               fd_v <= 1'b0;
            end
         end
      end
   end

   // reference: in-order execution
   logic [31:0] exp_op [NPROG][NS];
   bit          exec_f [NPROG];
   bit          seen_f [NPROG];
   int          n_stall = 0;
   int          n_flush = 0;

   task automatic build_ref();
      logic [31:0] r [32];
      int k;
      for (int i = 0; i < 32; i++) r[i] = rf_init(i);
      for (int i = 0; i < NPROG; i++) begin exec_f[i] = 0; seen_f[i] = 0; end
      k = 0;
      while (k < NPROG) begin
         ins_t c;
         logic [31:0] res;
         c = prog(5'(k));
         exec_f[k] = 1;
         exp_op[k][0] = r[c.sa];
         exp_op[k][1] = r[c.sb];
         exp_op[k][2] = r[c.sd];
         res = r[c.sa] + r[c.sb];
         if (c.ldf) res = res ^ LDK;
         if (c.we && c.dst != 5'd0) r[c.dst] = res;
         if (c.brf) k = int'(c.tgt); else k++;
      end
   endtask

   always @(negedge clk) begin
      if (shell_on) begin
         if (stall) n_stall++;
         if (flush) n_flush++;
         if (dx_v) begin
            seen_f[dx_i] = 1;
            // R10 end-to-end operands (D only for stores, R6)
            for (int i = 0; i < NS; i++) begin
               if (i < 2 || xi.st)
                  chk(ex_opnd[i*DW +: DW] === exp_op[dx_i][i], $sformatf("R10 instr %0d slot %0d", dx_i, i),
                      ex_opnd[i*DW +: DW], exp_op[dx_i][i]);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic clear_sweep();
      s_id_idx = '0; s_ex_idx = '0; s_id_rf = '0; s_ex_val = '0; s_use = '0;
      s_ex_dst = '0; s_mem_dst = '0; s_wb_dst = '0;
      s_ex_we = 0; s_ld = 0; s_br = 0; s_mem_we = 0; s_wb_we = 0;
      s_mem_res = '0; s_wb_res = '0;
   endtask

   initial begin
      clear_sweep();
      repeat (3) @(posedge clk);
      #5;
      // idle outputs with quiet inputs
      chk(stall === 1'b0, "R7 idle stall", 32'(stall), 0);
      chk(flush === 1'b0, "R8 idle flush", 32'(flush), 0);
      chk(bubble === 1'b0, "R9 idle bubble", 32'(bubble), 0);
      chk(ex_opnd === '0, "R2 idle ex", ex_opnd[31:0], 0);
      chk(id_opnd === '0, "R2 idle id", id_opnd[31:0], 0);
      @(negedge clk);
      rst_n = 1'b1;

      // decode bypass sweep, R1 / R2
      for (int p = 0; p < NS; p++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++)
               for (int we = 0; we < 2; we++) begin
                  logic [31:0] e;
                  clear_sweep();
                  s_id_idx[p*AW +: AW] = 5'(s);
                  s_id_rf[p*DW +: DW] = 32'hC000_0000 | 32'(s + 1);
                  s_wb_dst = 5'(w); s_wb_we = 1'(we); s_wb_res = 32'hB000_0000 | 32'(w + 1);
                  #2;
                  if (s == 0) e = 0;
                  else if (we == 1 && w == s) e = s_wb_res;
                  else e = s_id_rf[p*DW +: DW];
                  chk(id_opnd[p*DW +: DW] === e, (s == 0) ? "R2 id zero" : "R1 id bypass",
                      id_opnd[p*DW +: DW], e);
               end

      // execute forwarding sweep, R2..R5
      for (int p = 0; p < NS; p++)
         for (int s = 0; s < 4; s++)
            for (int m = 0; m < 4; m++)
               for (int mwe = 0; mwe < 2; mwe++)
                  for (int w = 0; w < 4; w++)
                     for (int wwe = 0; wwe < 2; wwe++) begin
                        logic [31:0] e;
                        string tag;
                        clear_sweep();
                        s_ex_idx[p*AW +: AW] = 5'(s);
                        s_ex_val[p*DW +: DW] = 32'hC000_0000 | 32'(s + 1);
                        s_mem_dst = 5'(m); s_mem_we = 1'(mwe); s_mem_res = 32'hA000_0000 | 32'(m + 1);
                        s_wb_dst = 5'(w); s_wb_we = 1'(wwe); s_wb_res = 32'hB000_0000 | 32'(w + 1);
                        #2;
                        if (s == 0) begin e = 0; tag = "R2 ex zero"; end
                        else if (mwe == 1 && m == s) begin e = s_mem_res; tag = "R3 ex mem"; end
                        else if (wwe == 1 && w == s) begin e = s_wb_res; tag = "R4 ex wb"; end
                        else begin e = s_ex_val[p*DW +: DW]; tag = "R5 ex latch"; end
                        chk(ex_opnd[p*DW +: DW] === e, tag, ex_opnd[p*DW +: DW], e);
                     end

      // three slots from three sources at once, R6
      clear_sweep();
      s_ex_idx = {5'd9, 5'd6, 5'd3};
      s_ex_val = {32'h0000_0D09, 32'h0000_0B06, 32'h0000_0A03};
      s_mem_dst = 5'd3; s_mem_we = 1; s_mem_res = 32'h1111_0003;
      s_wb_dst = 5'd6; s_wb_we = 1; s_wb_res = 32'h2222_0006;
      #2;
      chk(ex_opnd[31:0] === 32'h1111_0003, "R6 slot A", ex_opnd[31:0], 32'h1111_0003);
      chk(ex_opnd[63:32] === 32'h2222_0006, "R6 slot B", ex_opnd[63:32], 32'h2222_0006);
      chk(ex_opnd[95:64] === 32'h0000_0D09, "R6 slot D", ex_opnd[95:64], 32'h0000_0D09);

      // hazard sweep, R7 / R8 / R9
      for (int b = 0; b < 2; b++)
         for (int l = 0; l < 2; l++)
            for (int we = 0; we < 2; we++)
               for (int d = 0; d < 4; d++)
                  for (int p = 0; p < NS; p++)
                     for (int s = 0; s < 4; s++)
                        for (int u = 0; u < 2; u++) begin
                           bit es;
                           clear_sweep();
                           s_br = 1'(b); s_ld = 1'(l); s_ex_we = 1'(we); s_ex_dst = 5'(d);
                           s_id_idx[p*AW +: AW] = 5'(s); s_use[p] = 1'(u);
                           #2;
                           es = (b == 0) && (l == 1) && (we == 1) && (d != 0) && (u == 1) && (s == d);
                           chk(stall === es, "R7 stall", 32'(stall), 32'(es));
                           chk(flush === 1'(b), "R8 flush", 32'(flush), 32'(b));
                           chk(bubble === (es || b == 1), "R9 bubble", 32'(bubble), 32'(es || b == 1));
                        end

      // pipeline shell run, R10
      build_ref();
      clear_sweep();
      @(negedge clk);
      shell_on = 1'b1;
      repeat (60) @(posedge clk);
      @(negedge clk);
      #1;
      for (int k = 0; k < NPROG; k++)
         chk(seen_f[k] == exec_f[k], $sformatf("R10 instr %0d issued", k), 32'(seen_f[k]), 32'(exec_f[k]));
      chk(n_stall == 2, "R7 load-use stall cycles", 32'(n_stall), 2);
      chk(n_flush == 1, "R8 flush cycles", 32'(n_flush), 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule